// File: doc/BRIEF.md
# Timestamp Coherence Controller for a Shared Cache Bank

This block runs coherence for one small direct-mapped bank of a shared cache. Each line keeps a single global timestamp, which is the time by which every private copy of the line will have removed itself. The bank keeps no list of sharers. Private caches send reads and writes. A read carries the expiry time its requester wants, and a write carries the requester's own copy timestamp. Reads extend the line's timestamp and return it with the data. Writes complete at once, with no invalidation traffic. Each write raises the timestamp by one, and the stored value is compared with the writer's timestamp to detect writes to privately held data.

All timing decisions are made locally against a synchronized 32-bit time input. Misses go to a simple memory port that fetches and writes back whole words. A line that is still unexpired when its slot is needed by a miss is held in place until its timestamp passes. A one-cycle flash-invalidate input, used when the time counter wraps, writes back dirty lines and clears the bank. The bank serves one request per cycle in order. The line index is the low `IDX_W` address bits, and the tag is the rest.

Top module: `tsc_ctrl`

## Requirements
- R1: A read to a resident line is accepted and answered on the next cycle with kind 0 (read data). The reply carries the line data, and its time field is the larger of the stored timestamp and the requested expiry. That value becomes the new stored timestamp.
- R2: A line filled by reads from a single core becomes private to that core. An unexpired private line read by a different core becomes shared.
- R3: A read to an expired line sets the stored timestamp to the larger of the old value and the requested expiry, and makes the line private to the reader.
- R4: A write to a resident line is accepted without stalling, whatever its timestamp. It updates the data, marks the line dirty and raises the stored timestamp by exactly one. The reply appears on the next cycle.
- R5: A write to an unexpired private line whose local timestamp equals the stored timestamp is answered with kind 1 (plain acknowledge). The time field of that reply is 0.
- R6: Every other write to a resident line carries a completion time equal to the raised timestamp. The reply is kind 2 (acknowledge with time) when the local timestamp matched the stored one. Otherwise it is kind 3 (data with time) and returns the written data.
- R7: When a miss maps to a slot whose line is unexpired (time not greater than its timestamp), no memory access is made until the time passes that timestamp.
- R8: When a miss evicts a line that is dirty and expired, the line is written back to its own address before the new address is fetched. A clean victim is only replaced.
- R9: While a fill is outstanding, the only requests accepted are reads to the same line when the miss is a read miss. All other requests stall, and they are answered after the fill's replies.
- R10: Reads merged into one read miss each get a kind-0 reply, one per distinct core, in ascending core number. All of these replies carry the largest requested expiry, and the line becomes shared when two or more cores merged.
- R11: A write miss allocates the line with the written data and is answered with kind 2 and time 0. The line is left expired, so the next read makes it private with the requested expiry.
- R12: A private or shared line whose timestamp is below the current time becomes expired, and no later write to it counts as private.
- R13: A flash-invalidate pulse writes back every dirty line and then invalidates all lines, so the next access to any address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| now | input | 32 | Synchronized system time |
| flash_inv | input | 1 | One-cycle pulse: write back dirty lines and invalidate all |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_core | input | CORE_W | Requesting core number |
| req_addr | input | ADDR_W | Word address; low IDX_W bits select the line |
| req_ts | input | 32 | Requested expiry (read) or local copy timestamp (write) |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Reply present for one cycle |
| rsp_kind | output | 2 | 0 read data, 1 plain ack, 2 ack with time, 3 data with time |
| rsp_core | output | CORE_W | Core the reply is for |
| rsp_data | output | DATA_W | Line data (kinds 0 and 3) |
| rsp_ts | output | 32 | Expiry or completion time (0 for kind 1) |
| mem_req_valid | output | 1 | Memory access this cycle |
| mem_req_write | output | 1 | 1 = writeback, 0 = fetch |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_wdata | output | DATA_W | Writeback data |
| mem_rsp_valid | input | 1 | Fetch data returned |
| mem_rsp_data | input | DATA_W | Fetched word |

## Verification
Reads are tried with requested expiries both below and above the stored timestamp, so a reply that only echoes one of the two values is caught. Writes are tried with matching and mismatching local timestamps against private, shared, expired and freshly write-allocated lines, which separates all three write reply kinds. A full sweep of every core against every line, with rising expiries, exercises the private-to-shared step and the timestamp maximum on each slot. Miss patterns cover a live victim (hold), a dirty expired victim (writeback before fetch), three merged reads followed by a stalled write, and a flash clear followed by a re-read.

// File: rtl/tsc_pkg.sv
`timescale 1ns/1ps
package tsc_pkg;
    localparam int TS_W = 32;
    typedef logic [TS_W-1:0] ts_t;

    typedef enum logic [2:0] {
        LN_INV, LN_PRIV, LN_SHRD, LN_EXP, LN_RDMISS, LN_WRMISS, LN_HOLD
    } line_st_e;

    typedef enum logic [2:0] {
        CT_IDLE, CT_HOLD, CT_WB, CT_FETCH, CT_FILL, CT_DRAIN, CT_FLUSH
    } ctl_e;

    typedef enum logic [1:0] {
        RK_RDATA = 2'd0, RK_WACK = 2'd1, RK_WACK_TS = 2'd2, RK_WDATA_TS = 2'd3
    } rsp_kind_e;

    function automatic ts_t ts_max(input ts_t a, input ts_t b);
        return (a > b) ? a : b;
    endfunction

    // a timestamp has lapsed once the current time is strictly past it
    function automatic logic ts_passed(input ts_t t_now, input ts_t ts);
        return t_now > ts;
    endfunction

    function automatic logic readable(input line_st_e s);
        return s == LN_PRIV || s == LN_SHRD || s == LN_EXP;
    endfunction
endpackage

// File: rtl/tsc_lapse_scan.sv
`timescale 1ns/1ps
module tsc_lapse_scan import tsc_pkg::*; #(
    parameter int LINES = 4
) (
    input  ts_t             now,
    input  ts_t             gts [LINES],
    input  line_st_e        st  [LINES],
    output logic [LINES-1:0] lapsed
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign lapsed[i] = (st[i] == LN_PRIV || st[i] == LN_SHRD) && ts_passed(now, gts[i]);
    end
endmodule

// File: rtl/tsc_pick.sv
`timescale 1ns/1ps
module tsc_pick #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] mask,
    output logic [W-1:0] first,
    output logic         only_one
);
    always_comb begin
        first = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) first = W'(i);
        end
        only_one = ($countones(mask) <= 1);
    end
endmodule

// File: rtl/tsc_ctrl.sv
`timescale 1ns/1ps
module tsc_ctrl import tsc_pkg::*; #(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16,
    parameter int CORES  = 4,
    parameter int CORE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       now,
    input  logic              flash_inv,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [CORE_W-1:0] req_core,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_ts,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [CORE_W-1:0] rsp_core,
    output logic [DATA_W-1:0] rsp_data,
    output logic [31:0]       rsp_ts,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    localparam int LINES = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam logic [CORES-1:0] ONE = CORES'(1);

    line_st_e          st    [LINES];
    logic [TAG_W-1:0]  tag   [LINES];
    ts_t               gts   [LINES];
    logic [CORE_W-1:0] own   [LINES];
    logic [DATA_W-1:0] dat   [LINES];
    logic [LINES-1:0]  dirty;
    logic [LINES-1:0]  lapsed;

    ctl_e              ctl;
    logic [IDX_W-1:0]  m_idx, f_idx;
    logic [TAG_W-1:0]  m_tag;
    logic              m_write, flush_pend;
    logic [DATA_W-1:0] m_wdata;
    logic [CORE_W-1:0] m_core;
    ts_t               m_ts;
    logic [CORES-1:0]  m_rdmask;
    rsp_kind_e         rsp_kind_q;

    logic [CORE_W-1:0] p_first;
    logic              p_last;

    tsc_lapse_scan #(.LINES(LINES)) u_scan (.now(now), .gts(gts), .st(st), .lapsed(lapsed));
    tsc_pick #(.N(CORES), .W(CORE_W)) u_pick (.mask(m_rdmask), .first(p_first), .only_one(p_last));

    wire [IDX_W-1:0] r_idx = req_addr[IDX_W-1:0];
    wire [TAG_W-1:0] r_tag = req_addr[ADDR_W-1:IDX_W];
    wire hit      = (tag[r_idx] == r_tag) && readable(st[r_idx]);
    wire is_stale = (st[r_idx] == LN_EXP) || lapsed[r_idx];
    wire eff_priv = (st[r_idx] == LN_PRIV) && !lapsed[r_idx];
    wire ts_match = (req_ts == gts[r_idx]);
    wire vic_live = (st[r_idx] != LN_INV) && !ts_passed(now, gts[r_idx]);
    wire merge_ok = (ctl == CT_FILL) && !mem_rsp_valid && !m_write && !req_write &&
                    (r_idx == m_idx) && (r_tag == m_tag);
    wire acc      = req_valid && req_ready;
    wire ts_t rd_ts = ts_max(gts[r_idx], req_ts);

    assign req_ready = ((ctl == CT_IDLE) && !flush_pend) || merge_ok;
    assign rsp_kind  = rsp_kind_q;

    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        case (ctl)
            CT_WB: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = {tag[m_idx], m_idx};
                mem_req_wdata = dat[m_idx];
            end
            CT_FETCH: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = {m_tag, m_idx};
            end
            CT_FLUSH: begin
                mem_req_valid = dirty[f_idx];
                mem_req_write = 1'b1;
                mem_req_addr  = {tag[f_idx], f_idx};
                mem_req_wdata = dat[f_idx];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= CT_IDLE;
            for (int i = 0; i < LINES; i++) begin
                st[i] <= LN_INV; tag[i] <= '0; gts[i] <= '0; own[i] <= '0; dat[i] <= '0;
            end
            dirty <= '0; flush_pend <= 1'b0; f_idx <= '0;
            m_idx <= '0; m_tag <= '0; m_write <= 1'b0; m_wdata <= '0;
            m_core <= '0; m_ts <= '0; m_rdmask <= '0;
            rsp_valid <= 1'b0; rsp_kind_q <= RK_RDATA; rsp_core <= '0;
            rsp_data <= '0; rsp_ts <= '0;
        end else begin
            rsp_valid <= 1'b0;
            // timestamp expiry, overridden below where a request touches the line
            for (int i = 0; i < LINES; i++) begin
                if (lapsed[i]) st[i] <= LN_EXP;
            end
            case (ctl)
                CT_IDLE: begin
                    if (flush_pend) begin
                        ctl   <= CT_FLUSH;
                        f_idx <= '0;
                    end else if (acc && hit && !req_write) begin
                        gts[r_idx] <= rd_ts;
                        rsp_valid <= 1'b1; rsp_kind_q <= RK_RDATA; rsp_core <= req_core;
                        rsp_data <= dat[r_idx]; rsp_ts <= rd_ts;
                        if (is_stale) begin
                            st[r_idx]  <= LN_PRIV;
                            own[r_idx] <= req_core;
                        end else if (st[r_idx] == LN_PRIV && own[r_idx] != req_core) begin
                            st[r_idx] <= LN_SHRD;
                        end
                    end else if (acc && hit) begin
                        dat[r_idx]   <= req_wdata;
                        dirty[r_idx] <= 1'b1;
                        gts[r_idx]   <= gts[r_idx] + 1;
                        rsp_valid <= 1'b1; rsp_core <= req_core;
                        if (eff_priv && ts_match) begin
                            rsp_kind_q <= RK_WACK; rsp_ts <= '0; rsp_data <= '0;
                        end else if (ts_match) begin
                            rsp_kind_q <= RK_WACK_TS; rsp_ts <= gts[r_idx] + 1; rsp_data <= '0;
                        end else begin
                            rsp_kind_q <= RK_WDATA_TS; rsp_ts <= gts[r_idx] + 1; rsp_data <= req_wdata;
                        end
                    end else if (acc) begin
                        m_idx <= r_idx; m_tag <= r_tag; m_write <= req_write;
                        m_wdata <= req_wdata; m_core <= req_core; m_ts <= req_ts;
                        m_rdmask <= req_write ? '0 : (ONE << req_core);
                        if (vic_live) begin
                            st[r_idx] <= LN_HOLD;
                            ctl <= CT_HOLD;
                        end else if (st[r_idx] != LN_INV && dirty[r_idx]) begin
                            ctl <= CT_WB;
                        end else begin
                            ctl <= CT_FETCH;
                        end
                    end
                end
                CT_HOLD: begin
                    if (ts_passed(now, gts[m_idx])) ctl <= dirty[m_idx] ? CT_WB : CT_FETCH;
                end
                CT_WB: begin
                    dirty[m_idx] <= 1'b0;
                    ctl <= CT_FETCH;
                end
                CT_FETCH: begin
                    tag[m_idx] <= m_tag;
                    st[m_idx]  <= m_write ? LN_WRMISS : LN_RDMISS;
                    ctl <= CT_FILL;
                end
                CT_FILL: begin
                    if (acc) begin
                        m_rdmask <= m_rdmask | (ONE << req_core);
                        m_ts     <= ts_max(m_ts, req_ts);
                    end
                    if (mem_rsp_valid && m_write) begin
                        dat[m_idx] <= m_wdata; dirty[m_idx] <= 1'b1;
                        gts[m_idx] <= '0; st[m_idx] <= LN_EXP;
                        rsp_valid <= 1'b1; rsp_kind_q <= RK_WACK_TS; rsp_core <= m_core;
                        rsp_data <= '0; rsp_ts <= '0;
                        ctl <= CT_IDLE;
                    end else if (mem_rsp_valid) begin
                        dat[m_idx] <= mem_rsp_data; dirty[m_idx] <= 1'b0;
                        gts[m_idx] <= m_ts; own[m_idx] <= m_core;
                        st[m_idx]  <= ($countones(m_rdmask) > 1) ? LN_SHRD : LN_PRIV;
                        ctl <= CT_DRAIN;
                    end
                end
                CT_DRAIN: begin
                    rsp_valid <= 1'b1; rsp_kind_q <= RK_RDATA; rsp_core <= p_first;
                    rsp_data <= dat[m_idx]; rsp_ts <= gts[m_idx];
                    m_rdmask[p_first] <= 1'b0;
                    if (p_last) ctl <= CT_IDLE;
                end
                CT_FLUSH: begin
                    st[f_idx] <= LN_INV; dirty[f_idx] <= 1'b0; gts[f_idx] <= '0;
                    f_idx <= f_idx + 1'b1;
                    if (f_idx == IDX_W'(LINES - 1)) begin
                        ctl <= CT_IDLE;
                        flush_pend <= 1'b0;
                    end
                end
                default: ctl <= CT_IDLE;
            endcase
            if (flash_inv) flush_pend <= 1'b1;
        end
    end

    // R1: an accepted read hit replies next cycle covering both old and requested times
    p_rd_ts_covers_r1: assert property (@(posedge clk) disable iff (rst)
        (acc && hit && !req_write && ctl == CT_IDLE) |=>
        (rsp_valid && rsp_kind_q == RK_RDATA && rsp_ts >= $past(req_ts) && rsp_ts >= $past(gts[r_idx])));

    // R4: an accepted write hit bumps the line timestamp by one and replies next cycle
    p_wr_bump_r4: assert property (@(posedge clk) disable iff (rst)
        (acc && hit && req_write && ctl == CT_IDLE) |=>
        (rsp_valid && gts[$past(r_idx)] == $past(gts[r_idx]) + 1));

    // R7: a held victim keeps the controller waiting while its time has not passed
    p_hold_waits_r7: assert property (@(posedge clk) disable iff (rst)
        (ctl == CT_HOLD && !ts_passed(now, gts[m_idx])) |=> (ctl == CT_HOLD && !mem_req_valid));

    // R9: during a fill only same-line reads get in
    p_merge_only_reads_r9: assert property (@(posedge clk) disable iff (rst)
        (ctl == CT_FILL && acc) |-> (!req_write && req_addr == {m_tag, m_idx}));

    // R13: each flush step leaves its line invalid
    p_flush_clears_r13: assert property (@(posedge clk) disable iff (rst)
        (ctl == CT_FLUSH) |=> (st[$past(f_idx)] == LN_INV && !dirty[$past(f_idx)]));

    for (genvar gi = 0; gi < LINES; gi++) begin : g_chk
        // R12: an untouched private/shared line past its time turns expired
        p_lapse_to_exp_r12: assert property (@(posedge clk) disable iff (rst)
            (ctl == CT_IDLE && !req_valid && lapsed[gi]) |=> (st[gi] == LN_EXP));
    end
endmodule

// File: tb/sim_tsc_ctrl.sv
`timescale 1ns/1ps
module sim_tsc_ctrl;
    localparam int LAT = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] now = 32'd0;
    logic        flash_inv = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_core = '0;
    logic [5:0]  req_addr = '0;
    logic [31:0] req_ts = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [1:0]  rsp_kind, rsp_core;
    logic [15:0] rsp_data;
    logic [31:0] rsp_ts;
    logic        mem_req_valid, mem_req_write;
    logic [5:0]  mem_req_addr;
    logic [15:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [15:0] mem_rsp_data = '0;

    int checks = 0, errors = 0;
    int rd_count = 0, wr_count = 0;
    logic [15:0] mem [64];
    logic [1:0]  qk [$];
    logic [1:0]  qc [$];
    logic [15:0] qd [$];
    logic [31:0] qt [$];

    always #10 clk = ~clk;

    tsc_ctrl u0 (
        .clk(clk), .rst(rst), .now(now), .flash_inv(flash_inv),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_core(req_core), .req_addr(req_addr), .req_ts(req_ts), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_core(rsp_core),
        .rsp_data(rsp_data), .rsp_ts(rsp_ts),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data));

    function automatic logic [15:0] initv(input int a);
        return 16'(a * 16'h0111 + 16'h2000);
    endfunction

    // memory model and reply monitor
    initial begin
        int cnt = 0;
        logic [5:0] raddr = '0;
        for (int a = 0; a < 64; a++) mem[a] = initv(a);
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (!rst && rsp_valid) begin
                qk.push_back(rsp_kind); qc.push_back(rsp_core);
                qd.push_back(rsp_data); qt.push_back(rsp_ts);
            end
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem[raddr];
                end
            end
            if (!rst && mem_req_valid) begin
                if (mem_req_write) begin
                    mem[mem_req_addr] = mem_req_wdata;
                    wr_count++;
                end else begin
                    rd_count++;
                    raddr = mem_req_addr;
                    cnt = LAT;
                end
            end
        end
    end

    initial begin
        #(20 * 20000);
        errors++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // drive at a negedge; returns at the negedge after acceptance
    task automatic send(input logic w, input int core, input int addr,
                        input logic [31:0] ts, input logic [15:0] wd);
        req_valid = 1'b1; req_write = w; req_core = 2'(core);
        req_addr = 6'(addr); req_ts = ts; req_wdata = wd;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string tag, input logic [1:0] k, input int core,
                              input logic [15:0] d, input logic [31:0] ts);
        int waited = 0;
        while (qk.size() == 0 && waited < 60) begin @(negedge clk); waited++; end
        checks++;
        if (qk.size() == 0) begin
            errors++;
            $display("FAIL %s: got no reply expected kind %0d core %0d", tag, k, core);
        end else begin
            logic [1:0] gk = qk.pop_front();
            logic [1:0] gc = qc.pop_front();
            logic [15:0] gd = qd.pop_front();
            logic [31:0] gt = qt.pop_front();
            if (gk !== k || gc !== 2'(core) || gt !== ts ||
                ((k == 2'd0 || k == 2'd3) && gd !== d)) begin
                errors++;
                $display("FAIL %s: got kind %0d core %0d data %h ts %0d expected kind %0d core %0d data %h ts %0d",
                         tag, gk, gc, gd, gt, k, core, d, ts);
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int rc, wc;
        idle(3);
        rst = 1'b0;
        #1;
        chk("reset ready R9", {31'd0, req_ready}, 32'd1);
        chk("reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("reset mem idle", {31'd0, mem_req_valid}, 32'd0);
        @(negedge clk);
        now = 32'd100;

        // fill each slot with a single reader (R2, R10 single)
        for (int i = 0; i < 4; i++) begin
            rc = rd_count;
            send(1'b0, 0, i, 32'(150 + i), '0);
            expect_rsp("R10 single fill", 2'd0, 0, initv(i), 32'(150 + i));
            chk("R8 clean fetch count", 32'(rd_count), 32'(rc + 1));
        end
        // R1: lower request keeps time, higher raises it, no memory traffic
        rc = rd_count;
        send(1'b0, 0, 0, 32'd120, '0);
        expect_rsp("R1 lower expiry", 2'd0, 0, initv(0), 32'd150);
        send(1'b0, 0, 0, 32'd200, '0);
        expect_rsp("R1 higher expiry", 2'd0, 0, initv(0), 32'd200);
        chk("R1 no fetch on hit", 32'(rd_count), 32'(rc));

        // R5/R6/R4: private writes on line 1 (ts 151)
        send(1'b1, 0, 1, 32'd151, 16'h1111);
        expect_rsp("R5 private write", 2'd1, 0, '0, 32'd0);
        send(1'b1, 0, 1, 32'd151, 16'h2222);
        expect_rsp("R6 mismatch data+time R4 bump", 2'd3, 0, 16'h2222, 32'd153);
        send(1'b1, 0, 1, 32'd153, 16'h3333);
        expect_rsp("R5 private after bump", 2'd1, 0, '0, 32'd0);

        // R2: second core makes line 2 shared
        send(1'b0, 1, 2, 32'd160, '0);
        expect_rsp("R2 second reader", 2'd0, 1, initv(2), 32'd160);
        send(1'b1, 0, 2, 32'd160, 16'h4444);
        expect_rsp("R2 shared write ack+time R6", 2'd2, 0, '0, 32'd161);

        // R12 / R3: line 3 (ts 153) lapses at time 154
        now = 32'd154;
        @(negedge clk);
        send(1'b1, 0, 3, 32'd153, 16'h5555);
        expect_rsp("R12 lapsed not private", 2'd2, 0, '0, 32'd154);
        send(1'b0, 2, 3, 32'd300, '0);
        expect_rsp("R3 read of expired", 2'd0, 2, 16'h5555, 32'd300);
        send(1'b1, 2, 3, 32'd300, 16'h5AAA);
        expect_rsp("R3 reader now private", 2'd1, 2, '0, 32'd0);

        // R7: miss on slot 0 whose line (ts 200) is still live
        rc = rd_count; wc = wr_count;
        send(1'b0, 1, 4, 32'd400, '0);
        idle(8);
        chk("R7 no fetch while live", 32'(rd_count), 32'(rc));
        chk("R7 no reply while live", 32'(qk.size()), 32'd0);
        now = 32'd201;
        expect_rsp("R7 fill after expiry", 2'd0, 1, initv(4), 32'd400);
        chk("R8 clean victim no writeback", 32'(wr_count), 32'(wc));

        // R8: dirty expired victim on slot 1
        wc = wr_count;
        send(1'b0, 3, 5, 32'd500, '0);
        expect_rsp("R8 fill after writeback", 2'd0, 3, initv(5), 32'd500);
        chk("R8 writeback count", 32'(wr_count), 32'(wc + 1));
        chk("R8 writeback data", {16'd0, mem[1]}, 32'h3333);

        // R9/R10: three merged reads, then a stalled write
        send(1'b0, 0, 6, 32'd250, '0);
        send(1'b0, 2, 6, 32'd240, '0);
        send(1'b0, 1, 6, 32'd260, '0);
        send(1'b1, 3, 3, 32'd0, 16'h6666);
        expect_rsp("R10 merged core0", 2'd0, 0, initv(6), 32'd260);
        expect_rsp("R10 merged core1", 2'd0, 1, initv(6), 32'd260);
        expect_rsp("R10 merged core2", 2'd0, 2, initv(6), 32'd260);
        expect_rsp("R9 stalled write after fill", 2'd3, 3, 16'h6666, 32'd302);
        chk("R8 shared line written back", {16'd0, mem[2]}, 32'h4444);
        send(1'b1, 0, 6, 32'd260, 16'h7777);
        expect_rsp("R10 merged line shared", 2'd2, 0, '0, 32'd261);

        // R11: write miss
        now = 32'd1000;
        @(negedge clk);
        rc = rd_count;
        send(1'b1, 1, 8, 32'd0, 16'hBEEF);
        expect_rsp("R11 write miss ack", 2'd2, 1, '0, 32'd0);
        chk("R11 allocate fetch", 32'(rd_count), 32'(rc + 1));
        send(1'b0, 2, 8, 32'd1500, '0);
        expect_rsp("R11 read after write miss", 2'd0, 2, 16'hBEEF, 32'd1500);
        send(1'b1, 2, 8, 32'd1500, 16'hCAFE);
        expect_rsp("R11 reader private", 2'd1, 2, '0, 32'd0);

        // R13: flash invalidate
        wc = wr_count;
        flash_inv = 1'b1;
        @(negedge clk);
        flash_inv = 1'b0;
        idle(8);
        chk("R13 dirty writebacks", 32'(wr_count), 32'(wc + 3));
        chk("R13 slot0 data", {16'd0, mem[8]}, 32'hCAFE);
        chk("R13 slot2 data", {16'd0, mem[6]}, 32'h7777);
        chk("R13 slot3 data", {16'd0, mem[3]}, 32'h6666);
        rc = rd_count;
        send(1'b0, 0, 5, 32'd1200, '0);
        expect_rsp("R13 miss after flash", 2'd0, 0, initv(5), 32'd1200);
        chk("R13 refetch", 32'(rd_count), 32'(rc + 1));

        // sweep: every core reads every slot with rising expiry (R1, R2)
        now = 32'd1300;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            for (int c = 0; c < 4; c++) begin
                send(1'b0, c, i, 32'(1400 + 4 * i + c), '0);
                expect_rsp("R1 sweep read", 2'd0, c, mem[i], 32'(1400 + 4 * i + c));
            end
            send(1'b1, 3, i, 32'(1403 + 4 * i), 16'(16'h9000 + i));
            expect_rsp("R2 sweep shared write", 2'd2, 3, '0, 32'(1404 + 4 * i));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule